// File: doc/BRIEF.md
# Variable-Width FIFO SPI Master

This block is a register-programmed SPI controller. Software queues transmit entries into a small FIFO. Each entry carries its own bit count, from 1 to 24, so a single entry can shift a byte, a 12-bit sample or a 3-byte burst with no repacking. The engine pops one entry at a time and drives the serial clock from a programmable divider. Clock polarity, the output phase, the input sample point and the bit order of each direction are all configurable. Every received word lands right-aligned in a receive FIFO.

Two write addresses feed the same transmit FIFO. An entry written through the release address frees the chip select once its last bit has shifted. An entry written through the hold address keeps the select asserted, so a longer frame can be built from several entries. The serial clock rests for at least one bit time after every entry. A level interrupt can be enabled for an empty transmit queue, for an idle engine, or for both.

Top module: `vw_spi_master`

## Requirements
- R1: Registers sit at CTL0 0x00, CTL1 0x04, STATUS 0x08, release port 0x20 and hold port 0x30. After reset STATUS reads 0x0000_0280, CTL0 reads 0, `csN` is high, `sclk` is low and `irq` is low.
- R2: When CTL0[14] is set, a written entry takes its bit count from data[31:24]. When CTL0[14] is clear, the count comes from CTL0[5:0]. A count of 0 or above 24 runs 24 bits. The payload sits left-aligned in data[23:0].
- R3: Each `sclk` half period lasts speed+1 input clocks, where speed is CTL0[31:20]. An entry of n bits gives n `sclk` cycles, each 2*(speed+1) clocks long.
- R4: CTL0[7] sets the idle level of `sclk`. When CTL0[8] is set, `sclk` leaves its idle level in the same cycle that `csN` falls. When CTL0[8] is clear, `sclk` stays at its idle level in that cycle.
- R5: CTL0[6] set shifts the payload out from its top bit, and clear shifts it out from its lowest used bit. CTL1[1] set places received bits MSB-first, and clear places them LSB-first. A received word is always right-aligned in n bits, and reading it from 0x20 or 0x30 pops it.
- R6: CTL0[10] clear samples `miso` at the middle of each bit slot, that is at the end of the first `sclk` half. CTL0[10] set samples it at the end of the slot.
- R7: After an entry from 0x20, `csN` rises when its last bit completes. After an entry from 0x30, `csN` stays low into the next entry.
- R8: Between entries `sclk` stays idle for at least 2*(speed+1) clocks. After a release entry, `csN` stays high for at least that long.
- R9: STATUS holds the TX level in [31:24], the RX level in [23:16], overflow in [11], TX full in [10], TX empty in [9], RX full in [8], RX empty in [7], busy in [6] and the bit index in [5:0].
- R10: A write to either data port while the TX FIFO (4 deep) is full is dropped and sets the sticky overflow bit. The overflow bit is cleared only by CTL0[9].
- R11: While the RX FIFO (4 deep) is full, no new entry starts. The select stays high and the queue is held until a read frees a slot.
- R12: The engine runs only while CTL0[11] is set and CTL0[9] is clear. Writing CTL1=0 and then CTL0 with only bit 9 set aborts any transfer, raises `csN` and empties both FIFOs. STATUS then reads 0x0000_0280.
- R13: `irq` = (CTL1[6] and TX empty) or (CTL1[7] and not busy).
- R14: Busy is set from the cycle after an entry is loaded until the end of the idle gap that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe; pops RX at 0x20/0x30 |
| busAddr | input | 6 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 1 | Active-low chip select |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that software leaves the speed field, the polarity and the phase bits unchanged while an entry is shifting, and that `miso` is settled in the clock before each sample strobe. The stimulus keeps to these limits. It rewrites CTL0 only after the engine has gone idle, or through the abort sequence. It returns `miso` either straight from `mosi` or from `sclk` itself, so that every input bit is a stable function of the block's own outputs.

// File: rtl/vws_pkg.sv
package vws_pkg;
  localparam int DATA_W  = 24;
  localparam int CNT_W   = 5;
  localparam int IDX_W   = 5;
  localparam int SPEED_W = 12;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP} engState_t;

  typedef struct packed {
    logic              holdCs;
    logic [CNT_W-1:0]  nBits;
    logic [DATA_W-1:0] data;
  } txEntry_t;

  typedef struct packed {
    logic              load;
    logic              sample;
    logic              shift;
    logic              done;
    logic              abort;
    logic [IDX_W-1:0]  bitIdx;
  } strobe_t;

  typedef struct packed {
    logic [SPEED_W-1:0] speed;
    logic               cpol;
    logic               cphaOut;
    logic               cphaIn;
    logic               msbOut;
    logic               msbIn;
  } serCfg_t;

  function automatic logic [CNT_W-1:0] clampBits(input logic [7:0] raw);
    if (raw == 8'd0 || raw > 8'(DATA_W)) return CNT_W'(DATA_W);
    return raw[CNT_W-1:0];
  endfunction
endpackage

// File: rtl/vws_fifo.sv
module vws_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign full    = (level == LVL_W'(DEPTH));
  assign empty   = (level == '0);
  assign doPush  = push && !full;
  assign doPop   = pop && !empty;
  assign popData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      level <= level + LVL_W'(doPush) - LVL_W'(doPop);
    end
  end
endmodule

// File: rtl/vws_regs.sv
module vws_regs import vws_pkg::*; #(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [5:0]        busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  strobe_t           strb,
  input  logic              busy,
  input  logic [DATA_W-1:0] rxPushData,
  output serCfg_t           cfg,
  output logic              run,
  output txEntry_t          txHead,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              irq
);
  localparam logic [5:0] A_CTL0 = 6'h00;
  localparam logic [5:0] A_CTL1 = 6'h04;
  localparam logic [5:0] A_STAT = 6'h08;
  localparam logic [5:0] A_DATA = 6'h20;
  localparam logic [5:0] A_HOLD = 6'h30;
  localparam int TXL_W = $clog2(TX_DEPTH + 1);
  localparam int RXL_W = $clog2(RX_DEPTH + 1);

  logic [31:0] ctl0, ctl1;
  logic        txOvf, clr;
  logic        txPush, rxPop, txFull, rxEmpty;
  logic [TXL_W-1:0] txLvl;
  logic [RXL_W-1:0] rxLvl;
  logic [DATA_W-1:0] rxHead;
  txEntry_t    newEntry;
  logic [31:0] status;

  assign clr = ctl0[9];
  assign run = ctl0[11] && !clr;
  assign cfg.speed   = ctl0[31:20];
  assign cfg.cpol    = ctl0[7];
  assign cfg.cphaOut = ctl0[8];
  assign cfg.cphaIn  = ctl0[10];
  assign cfg.msbOut  = ctl0[6];
  assign cfg.msbIn   = ctl1[1];

  assign txPush = busWr && (busAddr == A_DATA || busAddr == A_HOLD);
  assign rxPop  = busRd && (busAddr == A_DATA || busAddr == A_HOLD);

  assign newEntry.holdCs = (busAddr == A_HOLD);
  assign newEntry.nBits  = clampBits(ctl0[14] ? busWdata[31:24] : {2'b00, ctl0[5:0]});
  assign newEntry.data   = busWdata[DATA_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctl0  <= '0;
      ctl1  <= '0;
      txOvf <= 1'b0;
    end else begin
      if (busWr && busAddr == A_CTL0) ctl0 <= busWdata;
      if (busWr && busAddr == A_CTL1) ctl1 <= busWdata;
      if (clr)                         txOvf <= 1'b0;
      else if (txPush && txFull)       txOvf <= 1'b1;
    end
  end

  vws_fifo #(.WIDTH($bits(txEntry_t)), .DEPTH(TX_DEPTH)) uTxFifo (
    .clk(clk), .rstN(rstN), .flush(clr),
    .push(txPush), .pushData(newEntry),
    .pop(strb.load), .popData(txHead),
    .level(txLvl), .full(txFull), .empty(txEmpty)
  );

  vws_fifo #(.WIDTH(DATA_W), .DEPTH(RX_DEPTH)) uRxFifo (
    .clk(clk), .rstN(rstN), .flush(clr),
    .push(strb.done), .pushData(rxPushData),
    .pop(rxPop), .popData(rxHead),
    .level(rxLvl), .full(rxFull), .empty(rxEmpty)
  );

  assign status = {8'(txLvl), 8'(rxLvl), 4'b0000, txOvf, txFull, txEmpty,
                   rxFull, rxEmpty, busy, 6'(strb.bitIdx)};

  always_comb begin
    case (busAddr)
      A_CTL0:         busRdata = ctl0;
      A_CTL1:         busRdata = ctl1;
      A_STAT:         busRdata = status;
      A_DATA, A_HOLD: busRdata = 32'(rxHead);
      default:        busRdata = '0;
    endcase
  end

  assign irq = (ctl1[6] && txEmpty) || (ctl1[7] && !busy);

  // R11: the engine never completes an entry into a full receive queue
  a_r11_no_rx_overrun: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |-> !rxFull);

  // R10: a dropped write leaves the sticky flag set
  a_r10_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (txPush && txFull && !clr) |=> txOvf);
endmodule

// File: rtl/vws_ctrl.sv
module vws_ctrl import vws_pkg::*; (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             txEmpty,
  input  logic             rxFull,
  input  logic [CNT_W-1:0] headBits,
  input  serCfg_t          cfg,
  output strobe_t          strb,
  output logic             busy,
  output logic             sclk
);
  engState_t          state;
  logic               halfB;
  logic [SPEED_W-1:0] divCnt;
  logic [IDX_W-1:0]   bitIdx;
  logic [CNT_W-1:0]   curBits;
  logic               halfTick, inShift, lastBit;

  assign halfTick = (divCnt >= cfg.speed);
  assign inShift  = run && (state == ST_SHIFT);
  assign lastBit  = (bitIdx == IDX_W'(curBits - 1'b1));

  assign strb.load   = run && (state == ST_IDLE) && !txEmpty && !rxFull;
  assign strb.abort  = !run;
  assign strb.sample = inShift && halfTick && (cfg.cphaIn ? halfB : !halfB);
  assign strb.done   = inShift && halfTick && halfB && lastBit;
  assign strb.shift  = inShift && halfTick && halfB && !lastBit;
  assign strb.bitIdx = bitIdx;

  assign busy = (state != ST_IDLE);
  assign sclk = cfg.cpol ^ ((state == ST_SHIFT) && (cfg.cphaOut ? !halfB : halfB));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      halfB   <= 1'b0;
      divCnt  <= '0;
      bitIdx  <= '0;
      curBits <= '0;
    end else if (!run) begin
      state  <= ST_IDLE;
      halfB  <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (strb.load) begin
            state   <= ST_SHIFT;
            curBits <= headBits;
            divCnt  <= '0;
            halfB   <= 1'b0;
            bitIdx  <= '0;
          end
        end
        ST_SHIFT: begin
          if (halfTick) begin
            divCnt <= '0;
            halfB  <= !halfB;
            if (halfB) begin
              if (lastBit) begin
                state  <= ST_GAP;
                bitIdx <= '0;
              end else begin
                bitIdx <= bitIdx + 1'b1;
              end
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (halfTick) begin
            divCnt <= '0;
            halfB  <= !halfB;
            if (halfB) state <= ST_IDLE;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R14: a loaded entry makes the engine busy on the next cycle
  a_r14_busy_after_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (busy || !run));

  // R8: every completed entry is followed by the idle gap
  a_r8_gap_follows_entry: assert property (@(posedge clk) disable iff (!rstN)
    (strb.done && run) |=> (!run || (state == ST_GAP && sclk == cfg.cpol)));
endmodule

// File: rtl/vws_datapath.sv
module vws_datapath import vws_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  txEntry_t          head,
  input  logic              msbOut,
  input  logic              msbIn,
  input  logic              miso,
  output logic              mosi,
  output logic              csActive,
  output logic [DATA_W-1:0] rxData
);
  logic [DATA_W-1:0] txShift, rxShift, rxIns;
  logic [CNT_W-1:0]  nLat;
  logic              holdLat;

  assign rxIns  = msbIn ? {rxShift[DATA_W-2:0], miso}
                        : (rxShift | (DATA_W'(miso) << strb.bitIdx));
  assign rxData = strb.sample ? rxIns : rxShift;
  assign mosi   = msbOut ? txShift[DATA_W-1] : txShift[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift  <= '0;
      rxShift  <= '0;
      nLat     <= '0;
      holdLat  <= 1'b0;
      csActive <= 1'b0;
    end else if (strb.abort) begin
      txShift  <= '0;
      csActive <= 1'b0;
    end else if (strb.load) begin
      holdLat  <= head.holdCs;
      nLat     <= head.nBits;
      txShift  <= msbOut ? head.data : (head.data >> (CNT_W'(DATA_W) - head.nBits));
      rxShift  <= '0;
      csActive <= 1'b1;
    end else begin
      if (strb.sample) rxShift <= rxIns;
      if (strb.shift)  txShift <= msbOut ? (txShift << 1) : (txShift >> 1);
      if (strb.done) begin
        txShift  <= '0;
        csActive <= holdLat;
      end
    end
  end

  // R5: a finished word never has bits above its own width
  a_r5_rx_right_aligned: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |-> ((rxData >> nLat) == '0));

  // R7: release-port entries free the select, hold-port entries keep it
  a_r7_release_select: assert property (@(posedge clk) disable iff (!rstN)
    (strb.done && !strb.abort && !holdLat) |=> !csActive);
  a_r7_hold_select: assert property (@(posedge clk) disable iff (!rstN)
    (strb.done && !strb.abort && holdLat) |=> csActive);
endmodule

// File: rtl/vw_spi_master.sv
module vw_spi_master import vws_pkg::*; #(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic        busRd,
  input  logic [5:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        csN,
  output logic        irq
);
  strobe_t           strb;
  serCfg_t           cfg;
  txEntry_t          txHead;
  logic              run, txEmpty, rxFull, busy, csActive;
  logic [DATA_W-1:0] rxPushData;

  vws_regs #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) uRegs (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .strb(strb), .busy(busy), .rxPushData(rxPushData),
    .cfg(cfg), .run(run), .txHead(txHead),
    .txEmpty(txEmpty), .rxFull(rxFull), .irq(irq)
  );

  vws_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .run(run), .txEmpty(txEmpty), .rxFull(rxFull),
    .headBits(txHead.nBits), .cfg(cfg), .strb(strb), .busy(busy), .sclk(sclk)
  );

  vws_datapath uData (
    .clk(clk), .rstN(rstN), .strb(strb), .head(txHead),
    .msbOut(cfg.msbOut), .msbIn(cfg.msbIn), .miso(miso),
    .mosi(mosi), .csActive(csActive), .rxData(rxPushData)
  );

  assign csN = !csActive;

  // R4: with the select released the serial clock rests at its idle level
  a_r4_idle_clock_deselected: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (sclk == cfg.cpol));
endmodule

// File: tb/sim_vw_spi_master.sv
module sim_vw_spi_master;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] A_CTL0 = 6'h00, A_CTL1 = 6'h04, A_STAT = 6'h08,
                         A_DATA = 6'h20, A_HOLD = 6'h30;

  logic clk = 1'b0, rstN = 1'b0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [5:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic sclk, mosi, miso, csN, irq;
  logic misoSel = 1'b0;

  int nChk = 0, nFail = 0;
  int cyc = 0, sclkRises = 0, csRises = 0, sclkPeriod = 0, lastSclkRise = 0;
  int csHighLen = 0, lastGap = 0;
  logic sclkAtCsFall = 1'b0, prevCs = 1'b1, prevSclk = 1'b0;
  logic finished = 1'b0;

  assign miso = misoSel ? sclk : mosi;

  always #(CLK_PERIOD/2) clk = !clk;

  vw_spi_master u0 (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .csN(csN), .irq(irq)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (sclk && !prevSclk) begin
      sclkRises    <= sclkRises + 1;
      sclkPeriod   <= cyc - lastSclkRise;
      lastSclkRise <= cyc;
    end
    if (csN && !prevCs) csRises <= csRises + 1;
    if (csN) csHighLen <= csHighLen + 1;
    if (!csN && prevCs) begin
      lastGap      <= csHighLen;
      csHighLen    <= 0;
      sclkAtCsFall <= sclk;
    end
    prevCs   <= csN;
    prevSclk <= sclk;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic pop, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRd = pop;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic waitDone();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(A_STAT, 1'b0, s);
      if (!s[6] && s[9]) return;
    end
    chk("R14 engine idle", 32'd0, 32'd1);
  endtask

  function automatic logic [31:0] mk0(int speed, bit en, bit clr, bit cpol, bit cphaO,
                                      bit cphaI, bit msbO, bit varW, int fixN);
    return (32'(speed) << 20) | (32'(varW) << 14) | (32'(en) << 11) | (32'(cphaI) << 10)
         | (32'(clr) << 9) | (32'(cphaO) << 8) | (32'(cpol) << 7) | (32'(msbO) << 6)
         | 32'(fixN & 63);
  endfunction

  function automatic logic [31:0] expRx(logic [23:0] d, int n, bit mo, bit mi);
    logic [23:0] v = d >> (24 - n);
    logic [23:0] r = '0;
    if (mo == mi) return 32'(v);
    for (int i = 0; i < n; i++) r[i] = v[n-1-i];
    return 32'(r);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    logic [31:0] s, d;
    int c0, r0;
    void'($urandom(32'h5eed));
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(A_STAT, 1'b0, s); chk("R1 status reset", s, 32'h0000_0280);
    rd(A_CTL0, 1'b0, s); chk("R1 ctl0 reset", s, 32'h0);
    chk("R1 csN reset", 32'(csN), 32'd1);
    chk("R1 sclk reset", 32'(sclk), 32'd0);
    chk("R1 irq reset", 32'(irq), 32'd0);

    // R13 interrupt sources
    wr(A_CTL1, 32'h40); chk("R13 irq tx empty", 32'(irq), 32'd1);
    wr(A_CTL1, 32'h80); chk("R13 irq idle", 32'(irq), 32'd1);
    wr(A_CTL1, 32'h00); chk("R13 irq off", 32'(irq), 32'd0);

    // R2 R5 random loopback transfers
    for (int it = 0; it < 32; it++) begin
      int sp = int'($urandom % 3);
      bit cp = 1'($urandom), co = 1'($urandom), ci = 1'($urandom);
      bit mo = 1'($urandom), mi = 1'($urandom);
      int n = 1 + int'($urandom % 24);
      logic [23:0] dat = 24'($urandom);
      wr(A_CTL0, mk0(sp, 1, 0, cp, co, ci, mo, 1, 0));
      wr(A_CTL1, 32'(mi) << 1);
      wr(A_DATA, {8'(n), dat});
      waitDone();
      rd(A_DATA, 1'b1, d);
      chk("R5 random loopback", d, expRx(dat, n, mo, mi));
    end

    // R2 fixed-width mode and clamping
    wr(A_CTL1, 32'h2);
    wr(A_CTL0, mk0(0, 1, 0, 0, 0, 0, 1, 0, 10));
    wr(A_DATA, 32'hFFA5_C3E1);
    waitDone(); rd(A_DATA, 1'b1, d);
    chk("R2 fixed width 10", d, expRx(24'hA5C3E1, 10, 1, 1));
    wr(A_CTL0, mk0(0, 1, 0, 0, 0, 0, 1, 1, 0));
    wr(A_DATA, 32'h1F12_3456);
    waitDone(); rd(A_DATA, 1'b1, d);
    chk("R2 count 31 runs 24", d, 32'h0012_3456);

    // R3 clock divider
    wr(A_CTL0, mk0(2, 1, 0, 0, 0, 0, 1, 1, 0));
    r0 = sclkRises;
    wr(A_DATA, 32'h18AB_CDEF);
    waitDone(); rd(A_DATA, 1'b1, d);
    chk("R3 sclk period", 32'(sclkPeriod), 32'd6);
    chk("R3 sclk cycles per entry", 32'(sclkRises - r0), 32'd24);

    // R4 polarity and output phase
    wr(A_CTL0, mk0(1, 1, 0, 1, 1, 0, 1, 1, 0));
    wr(A_DATA, 32'h0800_00AA);
    waitDone(); rd(A_DATA, 1'b1, d);
    chk("R4 idle high", 32'(sclk), 32'd1);
    chk("R4 phase1 first edge", 32'(sclkAtCsFall), 32'd0);
    wr(A_CTL0, mk0(1, 1, 0, 1, 0, 0, 1, 1, 0));
    wr(A_DATA, 32'h0800_00AA);
    waitDone(); rd(A_DATA, 1'b1, d);
    chk("R4 phase0 first edge", 32'(sclkAtCsFall), 32'd1);

    // R6 sample point: miso follows sclk
    misoSel = 1'b1;
    wr(A_CTL0, mk0(1, 1, 0, 0, 0, 0, 1, 1, 0));
    wr(A_DATA, 32'h0800_0000);
    waitDone(); rd(A_DATA, 1'b1, d);
    chk("R6 mid-slot sample", d, 32'h00);
    wr(A_CTL0, mk0(1, 1, 0, 0, 0, 1, 1, 1, 0));
    wr(A_DATA, 32'h0800_0000);
    waitDone(); rd(A_DATA, 1'b1, d);
    chk("R6 end-slot sample", d, 32'hFF);
    misoSel = 1'b0;

    // R7 R8 chip select and gap
    wr(A_CTL0, mk0(1, 1, 0, 0, 0, 0, 1, 1, 0));
    c0 = csRises;
    wr(A_HOLD, 32'h0800_0011);
    wr(A_DATA, 32'h0800_0022);
    waitDone();
    chk("R7 hold keeps select", 32'(csRises - c0), 32'd1);
    c0 = csRises;
    wr(A_DATA, 32'h0800_0033);
    wr(A_DATA, 32'h0800_0044);
    waitDone();
    chk("R7 release per entry", 32'(csRises - c0), 32'd2);
    chk("R8 min gap", 32'(lastGap >= 4), 32'd1);
    for (int k = 0; k < 4; k++) rd(A_DATA, 1'b1, d);

    // R9 R10 overflow and clear
    wr(A_CTL0, 32'h0);
    for (int k = 0; k < 5; k++) wr(A_DATA, 32'h0800_0000 | 32'(k));
    rd(A_STAT, 1'b0, s); chk("R10 R9 full with overflow", s, 32'h0400_0C80);
    wr(A_CTL0, 32'h200);
    rd(A_STAT, 1'b0, s); chk("R10 R12 clear", s, 32'h0000_0280);

    // R11 full receive queue stalls
    wr(A_CTL0, mk0(0, 1, 0, 0, 0, 0, 1, 1, 0));
    for (int k = 0; k < 4; k++) wr(A_DATA, 32'h0400_0000);
    waitDone();
    wr(A_DATA, 32'h0400_0000);
    repeat (200) @(negedge clk);
    rd(A_STAT, 1'b0, s); chk("R11 stalled", s, 32'h0104_0100);
    chk("R11 select high", 32'(csN), 32'd1);
    rd(A_DATA, 1'b1, d);
    waitDone();
    rd(A_STAT, 1'b0, s); chk("R11 resumed", s, 32'h0004_0300);
    for (int k = 0; k < 4; k++) rd(A_DATA, 1'b1, d);

    // R14 busy, R13 idle irq, R12 abort
    wr(A_CTL1, 32'h80);
    wr(A_CTL0, mk0(3, 1, 0, 0, 0, 0, 1, 1, 0));
    wr(A_DATA, 32'h1800_0F0F);
    repeat (10) @(negedge clk);
    rd(A_STAT, 1'b0, s); chk("R14 busy mid entry", 32'(s[6]), 32'd1);
    chk("R13 idle irq low while busy", 32'(irq), 32'd0);
    wr(A_CTL1, 32'h0);
    wr(A_CTL0, 32'h200);
    @(negedge clk);
    chk("R12 abort select", 32'(csN), 32'd1);
    rd(A_STAT, 1'b0, s); chk("R12 abort status", s, 32'h0000_0280);
    r0 = sclkRises;
    repeat (50) @(negedge clk);
    chk("R12 clock stopped", 32'(sclkRises - r0), 32'd0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule